// File: doc/BRIEF.md
# Prescaled Reload Event Counter

This block pairs a down-counting prescaler with a wide event counter. A single-cycle tick enable, produced elsewhere from a slower prescale clock (nominally 20 MHz) and already synchronous to the block clock, steps the prescaler by one. When the prescale count has reached zero, the following tick refills it from a programmable reload value and advances the event counter by one. A reload value of zero pins the prescale count at zero, so every tick then advances the event counter.

Software can overwrite the reload value, the live prescale count and the event count at any moment. Each has its own write strobe and all three share one data bus. Counting carries on from whatever state was written. All three values are presented continuously on output ports for a read path outside the block.

Counting is steered by a three-state phase machine. Its state always reflects the pair (count, reload). The states are:
- `PH_DESCEND`: the count is nonzero, and a tick decrements it.
- `PH_WRAP`: the count is zero and the reload is nonzero, so a tick reloads the count and bumps the event counter.
- `PH_STALL`: both are zero, so a tick leaves the count at zero and bumps the event counter.

After every cycle the phase machine makes a transition chosen from the values that the count and reload will hold next:
- It moves to `PH_DESCEND` when the next count is nonzero.
- It moves to `PH_WRAP` when the next count is zero and the next reload is nonzero.
- It moves to `PH_STALL` when both are zero.

Reset enters `PH_STALL`.

Top module: `prc_event_counter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the reload value, prescale count and event count all read zero.
- R2: A tick with a nonzero prescale count lowers the count by exactly one and leaves the event count unchanged; in a cycle with no tick and no write strobe, all three values hold.
- R3: A tick arriving while the prescale count is zero and the reload value is nonzero loads the count with the reload value and raises the event count by one, both in that same cycle.
- R4: While the reload value is zero and the count is zero, every tick keeps the count at zero and raises the event count by one.
- R5: With reload 5 and a starting count of 7, successive ticks give counts 6,5,4,3,2,1,0,5,4,3,2,1,0,5; the event count rises by one on the 8th and the 14th tick only.
- R6: Asserting `wr_reload`, `wr_count` or `wr_event` for one cycle makes the matching output equal the low bits of `wdata` in the next cycle, and later ticks count on from that written value.
- R7: A write strobe takes priority over a tick in the same cycle for its own register only; the other registers still follow the tick, and a tick in the same cycle as a reload write uses the old reload value.
- R8: The event count wraps from all ones to zero when it is incremented.
- R9: A written prescale count larger than the reload value is legal; it counts all the way down to zero before the first reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle prescale tick enable |
| wr_reload | input | 1 | Write strobe for the reload value |
| wr_count | input | 1 | Write strobe for the prescale count |
| wr_event | input | 1 | Write strobe for the event count |
| wdata | input | DATA_W (32) | Write data shared by all strobes |
| reload_q | output | PS_W (32) | Current reload value |
| count_q | output | PS_W (32) | Current prescale count |
| event_q | output | EV_W (32) | Current event count |

## Verification
All three registers drive the output ports directly. A wrong prescale or event value therefore shows one cycle after the tick or write that produced it. A phase state that disagrees with the count or reload shows within one tick: the count fails to reload, reloads too early, or the event count bumps on the wrong tick. The stimulus walks the full 7-down-to-reload example, writes colliding with ticks, wrap from all ones, and the zero-reload per-tick mode. At each of these the register contents decide the next tick.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic [1:0] {
        PH_DESCEND = 2'd0,
        PH_WRAP    = 2'd1,
        PH_STALL   = 2'd2
    } prc_phase_e;

    typedef struct packed {
        logic dec;
        logic load;
        logic bump;
    } prc_act_t;

endpackage

// File: rtl/prc_phase_fsm.sv
module prc_phase_fsm
    import prc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cnt_nxt_zero,
    input  logic       rel_nxt_zero,
    output prc_phase_e phase,
    output prc_act_t   act
);

    prc_phase_e phase_nxt;

    always_comb begin
        if (!cnt_nxt_zero)
            phase_nxt = PH_DESCEND;
        else if (!rel_nxt_zero)
            phase_nxt = PH_WRAP;
        else
            phase_nxt = PH_STALL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_STALL;
        else
            phase <= phase_nxt;
    end

    always_comb begin
        act = '0;
        unique case (phase)
            PH_DESCEND: act.dec  = tick;
            PH_WRAP: begin
                act.load = tick;
                act.bump = tick;
            end
            PH_STALL:   act.bump = tick;
            default:    act = '0;
        endcase
    end

endmodule

// File: rtl/prc_prescale_core.sv
module prc_prescale_core
    import prc_pkg::*;
#(
    parameter int PS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_reload,
    input  logic            wr_count,
    input  logic [PS_W-1:0] wdata,
    input  prc_act_t        act,
    output logic [PS_W-1:0] reload_q,
    output logic [PS_W-1:0] count_q,
    output logic            cnt_nxt_zero,
    output logic            rel_nxt_zero
);

    logic [PS_W-1:0] reload_nxt;
    logic [PS_W-1:0] count_nxt;

    always_comb begin
        reload_nxt = wr_reload ? wdata : reload_q;
        if (wr_count)
            count_nxt = wdata;
        else if (act.dec)
            count_nxt = count_q - 1'b1;
        else if (act.load)
            count_nxt = reload_q;
        else
            count_nxt = count_q;
    end

    assign cnt_nxt_zero = (count_nxt == '0);
    assign rel_nxt_zero = (reload_nxt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            count_q  <= '0;
        end else begin
            reload_q <= reload_nxt;
            count_q  <= count_nxt;
        end
    end

endmodule

// File: rtl/prc_event_ctr.sv
module prc_event_ctr #(
    parameter int EV_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_event,
    input  logic [EV_W-1:0] wdata,
    input  logic            bump,
    output logic [EV_W-1:0] event_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            event_q <= '0;
        else if (wr_event)
            event_q <= wdata;
        else if (bump)
            event_q <= event_q + 1'b1;
    end

endmodule

// File: rtl/prc_event_counter.sv
module prc_event_counter
    import prc_pkg::*;
#(
    parameter  int PS_W   = 32,
    parameter  int EV_W   = 32,
    localparam int DATA_W = (PS_W > EV_W) ? PS_W : EV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_reload,
    input  logic              wr_count,
    input  logic              wr_event,
    input  logic [DATA_W-1:0] wdata,
    output logic [PS_W-1:0]   reload_q,
    output logic [PS_W-1:0]   count_q,
    output logic [EV_W-1:0]   event_q
);

    prc_phase_e phase;
    prc_act_t   act;
    logic       cnt_nxt_zero;
    logic       rel_nxt_zero;

    prc_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .cnt_nxt_zero (cnt_nxt_zero),
        .rel_nxt_zero (rel_nxt_zero),
        .phase        (phase),
        .act          (act)
    );

    prc_prescale_core #(.PS_W(PS_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_reload    (wr_reload),
        .wr_count     (wr_count),
        .wdata        (wdata[PS_W-1:0]),
        .act          (act),
        .reload_q     (reload_q),
        .count_q      (count_q),
        .cnt_nxt_zero (cnt_nxt_zero),
        .rel_nxt_zero (rel_nxt_zero)
    );

    prc_event_ctr #(.EV_W(EV_W)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_event (wr_event),
        .wdata    (wdata[EV_W-1:0]),
        .bump     (act.bump),
        .event_q  (event_q)
    );

endmodule

// File: rtl/prc_event_counter_chk.sv
module prc_event_counter_chk
    import prc_pkg::*;
#(
    parameter int PS_W   = 32,
    parameter int EV_W   = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_reload,
    input logic              wr_count,
    input logic              wr_event,
    input logic [DATA_W-1:0] wdata,
    input logic [PS_W-1:0]   reload_q,
    input logic [PS_W-1:0]   count_q,
    input logic [EV_W-1:0]   event_q,
    input prc_phase_e        phase
);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (reload_q == '0 && count_q == '0 && event_q == '0));

    p_descend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_count && count_q != '0) |=> count_q == PS_W'($past(count_q) - 1'b1));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_count && !wr_event && !wr_reload) |=>
            ($stable(count_q) && $stable(event_q) && $stable(reload_q)));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_count && count_q == '0) |=> count_q == $past(reload_q));

    p_bump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_event && count_q == '0) |=> event_q == EV_W'($past(event_q) + 1'b1));

    p_no_bump_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_event && count_q != '0) |=> $stable(event_q));

    p_write_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> count_q == $past(wdata[PS_W-1:0]));

    p_write_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_event |=> event_q == $past(wdata[EV_W-1:0]));

    p_phase_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_DESCEND) == (count_q != '0)) &&
        ((phase == PH_STALL) == (count_q == '0 && reload_q == '0)));

endmodule

bind prc_event_counter prc_event_counter_chk #(
    .PS_W(PS_W), .EV_W(EV_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_reload(wr_reload),
    .wr_count(wr_count), .wr_event(wr_event), .wdata(wdata),
    .reload_q(reload_q), .count_q(count_q), .event_q(event_q), .phase(phase)
);

// File: tb/prc_event_counter_tb.sv
`timescale 1ns/1ps
module prc_event_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_reload = 1'b0;
    logic        wr_count = 1'b0;
    logic        wr_event = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] reload_q, count_q, event_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    prc_event_counter dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_reload(wr_reload),
        .wr_count(wr_count), .wr_event(wr_event), .wdata(wdata),
        .reload_q(reload_q), .count_q(count_q), .event_q(event_q)
    );

    // {tick, wr_reload, wr_count, wr_event, wdata, exp reload, exp count, exp event}
    localparam int NV = 31;
    localparam logic [131:0] VEC [NV] = '{
        {4'b0100, 32'd5, 32'd5, 32'd0, 32'd0},                 // R6
        {4'b0010, 32'd7, 32'd5, 32'd7, 32'd0},                 // R6
        {4'b1000, 32'd0, 32'd5, 32'd6, 32'd0},                 // R5
        {4'b1000, 32'd0, 32'd5, 32'd5, 32'd0},
        {4'b1000, 32'd0, 32'd5, 32'd4, 32'd0},
        {4'b1000, 32'd0, 32'd5, 32'd3, 32'd0},
        {4'b1000, 32'd0, 32'd5, 32'd2, 32'd0},
        {4'b1000, 32'd0, 32'd5, 32'd1, 32'd0},
        {4'b1000, 32'd0, 32'd5, 32'd0, 32'd0},
        {4'b1000, 32'd0, 32'd5, 32'd5, 32'd1},                 // 8th tick
        {4'b1000, 32'd0, 32'd5, 32'd4, 32'd1},
        {4'b1000, 32'd0, 32'd5, 32'd3, 32'd1},
        {4'b1000, 32'd0, 32'd5, 32'd2, 32'd1},
        {4'b1000, 32'd0, 32'd5, 32'd1, 32'd1},
        {4'b1000, 32'd0, 32'd5, 32'd0, 32'd1},
        {4'b1000, 32'd0, 32'd5, 32'd5, 32'd2},                 // 14th tick
        {4'b0000, 32'd0, 32'd5, 32'd5, 32'd2},                 // R2 hold
        {4'b1001, 32'hFFFF_FFFF, 32'd5, 32'd4, 32'hFFFF_FFFF}, // R7
        {4'b1010, 32'd0, 32'd5, 32'd0, 32'hFFFF_FFFF},         // R7
        {4'b1000, 32'd0, 32'd5, 32'd5, 32'd0},                 // R8
        {4'b1100, 32'd0, 32'd0, 32'd4, 32'd0},                 // R7
        {4'b1000, 32'd0, 32'd0, 32'd3, 32'd0},                 // R2
        {4'b1000, 32'd0, 32'd0, 32'd2, 32'd0},
        {4'b1000, 32'd0, 32'd0, 32'd1, 32'd0},
        {4'b1000, 32'd0, 32'd0, 32'd0, 32'd0},
        {4'b1000, 32'd0, 32'd0, 32'd0, 32'd1},                 // R4
        {4'b1000, 32'd0, 32'd0, 32'd0, 32'd2},                 // R4
        {4'b0000, 32'd0, 32'd0, 32'd0, 32'd2},                 // R2
        {4'b1100, 32'd2, 32'd2, 32'd0, 32'd3},                 // R7 old reload
        {4'b1000, 32'd0, 32'd2, 32'd2, 32'd4},                 // R3
        {4'b1000, 32'd0, 32'd2, 32'd1, 32'd4}                  // R2
    };
    localparam int VREQ [NV] = '{6,6,5,5,5,5,5,5,5,5,5,5,5,5,5,5,2,7,7,8,7,2,2,2,2,4,4,2,7,3,2};

    function automatic string rtag(int n);
        case (n)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check3(string tag, logic [31:0] er, logic [31:0] ec, logic [31:0] ee);
        n_chk++;
        if (reload_q !== er || count_q !== ec || event_q !== ee) begin
            n_bad++;
            $display("FAIL %s: got reload=%0h count=%0h event=%0h, expected reload=%0h count=%0h event=%0h",
                     tag, reload_q, count_q, event_q, er, ec, ee);
        end
    endtask

    task automatic apply(logic [3:0] ctl, logic [31:0] d);
        {tick, wr_reload, wr_count, wr_event} = ctl;
        wdata = d;
        @(negedge clk);
        {tick, wr_reload, wr_count, wr_event} = 4'b0000;
        wdata = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check3("R1 in reset", 32'd0, 32'd0, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1 after release", 32'd0, 32'd0, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][131:128], VEC[i][127:96]);
            check3($sformatf("%s row %0d", rtag(VREQ[i]), i),
                   VEC[i][95:64], VEC[i][63:32], VEC[i][31:0]);
        end

        // R9: count above reload runs fully down first (event base is 4)
        apply(4'b0100, 32'd1);
        apply(4'b0010, 32'd3);
        check3("R9 setup", 32'd1, 32'd3, 32'd4);
        apply(4'b1000, 32'd0); check3("R9 t1", 32'd1, 32'd2, 32'd4);
        apply(4'b1000, 32'd0); check3("R9 t2", 32'd1, 32'd1, 32'd4);
        apply(4'b1000, 32'd0); check3("R9 t3", 32'd1, 32'd0, 32'd4);
        apply(4'b1000, 32'd0); check3("R9 t4", 32'd1, 32'd1, 32'd5);
        apply(4'b1000, 32'd0); check3("R9 t5", 32'd1, 32'd0, 32'd5);
        apply(4'b1000, 32'd0); check3("R9 t6", 32'd1, 32'd1, 32'd6);

        // R7: all three written alongside a tick, writes win everywhere
        apply(4'b1111, 32'd9);
        check3("R7 all writes", 32'd9, 32'd9, 32'd9);

        // R1: reset from a busy state
        rst_n = 1'b0;
        @(negedge clk);
        check3("R1 mid-run reset", 32'd0, 32'd0, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R1 post mid-run", 32'd0, 32'd0, 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no finish, expected finish within budget");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule